// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block gathers hardware event pulses from three sources (transmit, receive and miscellaneous) into three 32-bit cause banks and drives one level-sensitive host interrupt line. Each bank has a cause register and a per-bit clear-mode register. Each clear-mode bit picks one of two ways to clear its cause bit: the bit clears when the cause register is read, or it clears when a 1 is written to it. Each bank also has a software set port that raises causes, separate write-1 ports that set and clear mask bits, and a mask readback with no side effects.

A three-bit summary register holds one bit per bank. A bank's bit is set whenever that bank has a pending cause that is not masked. The summary bit stays set until the summary register is read. A separate summary mask decides which banks may drive the interrupt line. The interrupt output is a register, so it rises one clock after an unmasked cause becomes visible.

Host access uses a single-cycle port. Read data is combinational from the address. Side effects of a read, or the effect of a write, take place at the clock edge that ends the access cycle.

Top module: `irq_cause_unit`

## Requirements
- R1: Word address map, with bank index b (0 = TX, 1 = RX, 2 = MISC) at base 8*b. The offsets are: +0 cause, +1 clear mode, +2 software set (write only, reads 0), +3 mask-set, +4 mask-clear (both write only, read 0) and +5 mask value. The summary register is at 24 and the summary mask at 25. After reset all causes and clear modes read 0, every bank mask reads 0xFFFFFFFF, the summary reads 0, the summary mask reads 0x7 and the interrupt line is low.
- R2: A 1 on any bit of a bank's event input for one cycle sets that cause bit. The bit stays set after the pulse ends.
- R3: A cause bit whose clear-mode bit is 0 clears only when a 1 is written to it. Writing 0 to it, or reading it, leaves it set.
- R4: A cause bit whose clear-mode bit is 1 is returned by a cause read and is cleared by that read. Writing 1 to it has no effect.
- R5: Writing 1s to mask-set sets those mask bits, and writing 1s to mask-clear clears them. Zero bits in either write leave the mask unchanged. Reading the mask value changes nothing.
- R6: Writing 1s to the software set register makes those cause bits pending.
- R7: Summary bit b (bit 0 = TX, bit 1 = RX, bit 2 = MISC) is set when bank b has a cause bit that is set and not masked. Masked causes do not contribute. Bits 3 and above read 0, so the low byte can never read 0xFF.
- R8: Reading the summary register clears it. A bank that is still pending sets its bit again at the same edge, so a later read returns it again.
- R9: A 1 in summary-mask bit b keeps bank b from driving the interrupt line. It does not hide the bank's bit in the summary readback.
- R10: The interrupt line is a register. It goes high one cycle after an unmasked cause bit becomes visible, and it stays high while any unmasked summary bit is set.
- R11: If an event pulse and a clear (a write-1 clear or a clearing read) hit the same cause bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| tx_evt | input | 32 | TX event pulses, one per cause bit |
| rx_evt | input | 32 | RX event pulses, one per cause bit |
| misc_evt | input | 32 | MISC event pulses, one per cause bit |
| irq_o | output | 1 | Host interrupt line |

## Verification
The case that can fail quietly is a hardware event that lands in the same cycle as an acknowledge aimed at the same cause bit. The bench forces this in both clear modes. In the write-1 mode it drives a write of 1 to a TX cause bit together with an event pulse on that bit. In the read-clear mode it reads the MISC cause register while pulsing the matching event. The bench passes the case only if the bit still reads as pending afterwards, and in the read case only if the colliding read also returned it as set. A checker property makes the same demand after every event pulse.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  parameter int unsigned DATA_W    = 32;
  parameter int unsigned NUM_BANKS = 3;
  parameter int unsigned BANK_SPAN = 8;
  parameter int unsigned ADDR_W    = $clog2((NUM_BANKS + 1) * BANK_SPAN);

  // Per-bank register offsets
  parameter int unsigned OFS_CAUSE = 0;
  parameter int unsigned OFS_MODE  = 1;
  parameter int unsigned OFS_SET   = 2;
  parameter int unsigned OFS_MSET  = 3;
  parameter int unsigned OFS_MCLR  = 4;
  parameter int unsigned OFS_MVAL  = 5;

  // Summary registers sit just past the last bank
  parameter int unsigned SUM_CAUSE_ADDR = NUM_BANKS * BANK_SPAN;
  parameter int unsigned SUM_MASK_ADDR  = NUM_BANKS * BANK_SPAN + 1;

  typedef struct packed {
    logic cause_wr;
    logic cause_rd;
    logic mode_wr;
    logic set_wr;
    logic mset_wr;
    logic mclr_wr;
  } bank_strobe_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_cause_pkg::*;
#(
  parameter int unsigned NB = NUM_BANKS,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  output bank_strobe_t [NB-1:0] strb_o,
  output logic                  sum_rd_o,
  output logic                  smask_wr_o
);

  localparam int unsigned OW = $clog2(BANK_SPAN);
  localparam int unsigned SW = AW - OW;

  logic [OW-1:0] ofs;
  logic [SW-1:0] sel;

  assign ofs = addr[OW-1:0];
  assign sel = addr[AW-1:OW];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [SW-1:0] SEL = SW'(b);
    logic hit;
    assign hit = (sel == SEL);
    assign strb_o[b].cause_wr = wr_en & hit & (ofs == OW'(OFS_CAUSE));
    assign strb_o[b].cause_rd = rd_en & hit & (ofs == OW'(OFS_CAUSE));
    assign strb_o[b].mode_wr  = wr_en & hit & (ofs == OW'(OFS_MODE));
    assign strb_o[b].set_wr   = wr_en & hit & (ofs == OW'(OFS_SET));
    assign strb_o[b].mset_wr  = wr_en & hit & (ofs == OW'(OFS_MSET));
    assign strb_o[b].mclr_wr  = wr_en & hit & (ofs == OW'(OFS_MCLR));
  end

  assign sum_rd_o   = rd_en & (addr == AW'(SUM_CAUSE_ADDR));
  assign smask_wr_o = wr_en & (addr == AW'(SUM_MASK_ADDR));

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_cause_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bank_strobe_t strb,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] cause_o,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] mask_o,
  output logic          pend_o
);

  logic [DW-1:0] cause_q, cause_d;
  logic [DW-1:0] mode_q,  mode_d;
  logic [DW-1:0] mask_q,  mask_d;
  logic [DW-1:0] clr_vec, set_vec;
  logic          mode_en, mask_en;

  // Next state: events and software set take priority over any clear
  always_comb begin
    clr_vec = '0;
    if (strb.cause_wr) clr_vec = clr_vec | (wdata & ~mode_q);
    if (strb.cause_rd) clr_vec = clr_vec | mode_q;
    set_vec = evt;
    if (strb.set_wr)   set_vec = set_vec | wdata;
    cause_d = (cause_q & ~clr_vec) | set_vec;

    mode_en = strb.mode_wr;
    mode_d  = wdata;

    mask_en = strb.mset_wr | strb.mclr_wr;
    mask_d  = mask_q;
    if (strb.mset_wr) mask_d = mask_d | wdata;
    if (strb.mclr_wr) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mode_q  <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= cause_d;
      if (mode_en) mode_q <= mode_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign cause_o = cause_q;
  assign mode_o  = mode_q;
  assign mask_o  = mask_q;
  assign pend_o  = |(cause_q & ~mask_q);

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bank_pend,
  input  logic          sum_rd,
  input  logic          smask_wr,
  input  logic [NB-1:0] smask_wdata,
  output logic [NB-1:0] sum_o,
  output logic [NB-1:0] smask_o,
  output logic          irq_o
);

  logic [NB-1:0] sum_q,   sum_d;
  logic [NB-1:0] smask_q, smask_d;
  logic          irq_q,   irq_d;

  // A clearing read loses to a bank that is still pending
  always_comb begin
    sum_d   = (sum_q & ~{NB{sum_rd}}) | bank_pend;
    smask_d = smask_wdata;
    irq_d   = |(sum_d & ~smask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      smask_q <= '1;
      irq_q   <= 1'b0;
    end else begin
      sum_q <= sum_d;
      if (smask_wr) smask_q <= smask_d;
      irq_q <= irq_d;
    end
  end

  assign sum_o   = sum_q;
  assign smask_o = smask_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] tx_evt,
  input  logic [DW-1:0] rx_evt,
  input  logic [DW-1:0] misc_evt,
  output logic          irq_o
);

  localparam int unsigned NB = NUM_BANKS;
  localparam int unsigned OW = $clog2(BANK_SPAN);
  localparam int unsigned SW = AW - OW;

  logic [1:0]             rst_sync;
  logic                   rst_sync_n;
  bank_strobe_t [NB-1:0]  strb;
  logic                   sum_rd, smask_wr;
  logic [NB-1:0][DW-1:0]  evt_vec, cause_vec, mode_vec, mask_vec;
  logic [NB-1:0]          pend_vec, sum_vec, smask_vec;

  // Reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign evt_vec[0] = tx_evt;
  assign evt_vec[1] = rx_evt;
  assign evt_vec[2] = misc_evt;

  irq_addr_decode #(.NB(NB), .AW(AW)) dec_i (
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .strb_o     (strb),
    .sum_rd_o   (sum_rd),
    .smask_wr_o (smask_wr)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irq_cause_bank #(.DW(DW)) bank_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .strb    (strb[b]),
      .wdata   (wdata),
      .evt     (evt_vec[b]),
      .cause_o (cause_vec[b]),
      .mode_o  (mode_vec[b]),
      .mask_o  (mask_vec[b]),
      .pend_o  (pend_vec[b])
    );
  end

  irq_summary #(.NB(NB)) sum_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bank_pend   (pend_vec),
    .sum_rd      (sum_rd),
    .smask_wr    (smask_wr),
    .smask_wdata (wdata[NB-1:0]),
    .sum_o       (sum_vec),
    .smask_o     (smask_vec),
    .irq_o       (irq_o)
  );

  // Read mux
  always_comb begin
    rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr[AW-1:OW] == SW'(b)) begin
        case (addr[OW-1:0])
          OW'(OFS_CAUSE): rdata = cause_vec[b];
          OW'(OFS_MODE):  rdata = mode_vec[b];
          OW'(OFS_MVAL):  rdata = mask_vec[b];
          default:        rdata = '0;
        endcase
      end
    end
    if (addr == AW'(SUM_CAUSE_ADDR)) rdata = DW'(sum_vec);
    if (addr == AW'(SUM_MASK_ADDR))  rdata = DW'(smask_vec);
  end

endmodule

// File: rtl/irq_cause_sva.sv
module irq_cause_sva #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5,
  parameter int unsigned NB = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [AW-1:0]        addr,
  input logic [DW-1:0]        wdata,
  input logic [DW-1:0]        rdata,
  input logic [NB-1:0][DW-1:0] evt_vec,
  input logic [NB-1:0][DW-1:0] cause_vec,
  input logic [NB-1:0][DW-1:0] mode_vec,
  input logic [NB-1:0][DW-1:0] mask_vec,
  input logic [NB-1:0]        sum_vec,
  input logic [NB-1:0]        smask_vec,
  input logic                 irq_o
);

  localparam logic [AW-1:0] SUM_ADDR = AW'(NB * 8);

  for (genvar b = 0; b < NB; b++) begin : g_chk
    localparam logic [AW-1:0] BASE = AW'(b * 8);

    // R11: an event pulse always leaves its bit pending
    a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_vec[b]) |=> ((cause_vec[b] & $past(evt_vec[b])) == $past(evt_vec[b])));

    // R4: a cause read empties every read-clear bit not re-raised
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == BASE) |=>
        ((cause_vec[b] & $past(mode_vec[b]) & ~$past(evt_vec[b])) == '0));

    // R5: mask-set port
    a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == BASE + AW'(3)) |=> ((mask_vec[b] & $past(wdata)) == $past(wdata)));

    // R5: mask-clear port
    a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == BASE + AW'(4)) |=> ((mask_vec[b] & $past(wdata)) == '0));
  end

  // R7: the summary low byte never reads as all ones
  a_r7_no_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SUM_ADDR) |-> (rdata[7:0] != 8'hFF));

  // R9: fully masked summary keeps the line low
  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smask_vec) == '1) |-> !irq_o);

  // R10: the line is high only with an unmasked summary bit behind it
  a_r10_irq_backed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(sum_vec & ~$past(smask_vec))));

endmodule

bind irq_cause_unit irq_cause_sva #(.DW(DW), .AW(AW), .NB(NB)) sva_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .evt_vec   (evt_vec),
  .cause_vec (cause_vec),
  .mode_vec  (mode_vec),
  .mask_vec  (mask_vec),
  .sum_vec   (sum_vec),
  .smask_vec (smask_vec),
  .irq_o     (irq_o)
);

// File: tb/irq_cause_unit_tb_top.sv
module irq_cause_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] tx_evt = '0, rx_evt = '0, misc_evt = '0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_cause_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .misc_evt(misc_evt), .irq_o(irq_o)
  );

  localparam int TXB = 0, RXB = 1, MSB = 2;
  localparam logic [4:0] SUM_A = 5'd24, SMASK_A = 5'd25;

  function automatic logic [4:0] ra(input int b, input int ofs);
    return 5'(b * 8 + ofs);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input string what,
                        input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic pulse(input int b, input logic [31:0] v);
    if (b == TXB) tx_evt = v; else if (b == RXB) rx_evt = v; else misc_evt = v;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; misc_evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "irq after reset", 32'(irq_o), 32'h0);
    for (int b = 0; b < 3; b++) begin
      rd_chk("R1", "cause reset", ra(b, 0), 32'h0);
      rd_chk("R1", "mode reset",  ra(b, 1), 32'h0);
      rd_chk("R1", "set reads 0", ra(b, 2), 32'h0);
      rd_chk("R1", "mask reset",  ra(b, 5), 32'hFFFF_FFFF);
    end
    rd_chk("R1", "summary reset", SUM_A, 32'h0);
    rd_chk("R1", "summary mask reset", SMASK_A, 32'h7);
  endtask

  task automatic t_event_w1c;
    pulse(TXB, 32'h8);
    rd_chk("R2", "event latched", ra(TXB, 0), 32'h8);
    rd_chk("R3", "read keeps w1c bit", ra(TXB, 0), 32'h8);
    wr(ra(TXB, 0), 32'h0);
    rd_chk("R3", "write 0 keeps bit", ra(TXB, 0), 32'h8);
    wr(ra(TXB, 0), 32'h8);
    rd_chk("R3", "write 1 clears", ra(TXB, 0), 32'h0);
  endtask

  task automatic t_mask;
    wr(ra(RXB, 4), 32'h0000_00F0);
    rd_chk("R5", "mask clear", ra(RXB, 5), 32'hFFFF_FF0F);
    wr(ra(RXB, 4), 32'h0);
    wr(ra(RXB, 3), 32'h0);
    rd_chk("R5", "zero writes no change", ra(RXB, 5), 32'hFFFF_FF0F);
    rd_chk("R5", "readback no side effect", ra(RXB, 5), 32'hFFFF_FF0F);
    wr(ra(RXB, 3), 32'h0000_0010);
    rd_chk("R5", "mask set", ra(RXB, 5), 32'hFFFF_FF1F);
    wr(ra(RXB, 3), 32'hFFFF_FFFF);
    rd_chk("R5", "mask restored", ra(RXB, 5), 32'hFFFF_FFFF);
  endtask

  task automatic t_swset;
    wr(ra(RXB, 2), 32'h4000_0000);
    rd_chk("R6", "software set", ra(RXB, 0), 32'h4000_0000);
    wr(ra(RXB, 0), 32'h4000_0000);
    rd_chk("R6", "software set cleared", ra(RXB, 0), 32'h0);
  endtask

  task automatic t_cor;
    wr(ra(MSB, 1), 32'h0000_00FF);
    rd_chk("R4", "mode readback", ra(MSB, 1), 32'h0000_00FF);
    pulse(MSB, 32'h101);
    rd_chk("R4", "first read", ra(MSB, 0), 32'h101);
    rd_chk("R4", "read cleared cor bit", ra(MSB, 0), 32'h100);
    pulse(MSB, 32'h1);
    wr(ra(MSB, 0), 32'h1);
    rd_chk("R4", "write ignored on cor bit", ra(MSB, 0), 32'h101);
    rd_chk("R4", "second read clear", ra(MSB, 0), 32'h100);
    wr(ra(MSB, 0), 32'h100);
    rd_chk("R3", "w1c bit in mixed bank", ra(MSB, 0), 32'h0);
  endtask

  task automatic t_irq;
    wr(ra(TXB, 4), 32'h1);
    wr(SMASK_A, 32'h0);
    pulse(TXB, 32'h1);
    chk("R10", "irq not yet", 32'(irq_o), 32'h0);
    idle(1);
    chk("R10", "irq one cycle later", 32'(irq_o), 32'h1);
    rd_chk("R7", "tx summary bit", SUM_A, 32'h1);
    rd_chk("R8", "still pending re-sets", SUM_A, 32'h1);
    wr(ra(TXB, 0), 32'h1);
    chk("R10", "irq held by summary", 32'(irq_o), 32'h1);
    rd_chk("R8", "sticky summary", SUM_A, 32'h1);
    rd_chk("R8", "cleared by read", SUM_A, 32'h0);
    chk("R10", "irq dropped", 32'(irq_o), 32'h0);
    pulse(TXB, 32'h20);
    idle(2);
    rd_chk("R7", "masked cause ignored", SUM_A, 32'h0);
    chk("R7", "masked cause no irq", 32'(irq_o), 32'h0);
    wr(ra(TXB, 0), 32'h20);
  endtask

  task automatic t_smask;
    wr(SMASK_A, 32'h1);
    pulse(TXB, 32'h1);
    idle(2);
    chk("R9", "bank masked from line", 32'(irq_o), 32'h0);
    rd_chk("R9", "summary raw visible", SUM_A, 32'h1);
    wr(SMASK_A, 32'h0);
    idle(2);
    chk("R9", "unmasked drives line", 32'(irq_o), 32'h1);
    wr(ra(TXB, 0), 32'h1);
    idle(1);
    rd_chk("R8", "drain", SUM_A, 32'h1);
    rd_chk("R8", "drained", SUM_A, 32'h0);
    chk("R9", "line low after drain", 32'(irq_o), 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(ra(RXB, 4), 32'h2);
    wr(ra(MSB, 4), 32'h200);
    rx_evt = 32'h2; misc_evt = 32'h200;
    @(negedge clk);
    rx_evt = '0; misc_evt = '0;
    idle(1);
    rd(SUM_A, v);
    chk("R7", "rx and misc summary bits", v, 32'h6);
    chk("R7", "low byte not all ones", 32'(v[7:0] == 8'hFF), 32'h0);
    chk("R10", "line up", 32'(irq_o), 32'h1);
    wr(ra(RXB, 0), 32'h2);
    wr(ra(MSB, 0), 32'h200);
    idle(1);
    rd(SUM_A, v);
    rd_chk("R8", "map drained", SUM_A, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    pulse(TXB, 32'h4);
    wr_en = 1'b1; addr = ra(TXB, 0); wdata = 32'h4; tx_evt = 32'h4;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; tx_evt = '0;
    rd_chk("R11", "w1c collision keeps bit", ra(TXB, 0), 32'h4);
    wr(ra(TXB, 0), 32'h4);
    rd_chk("R3", "collision bit cleared", ra(TXB, 0), 32'h0);
    pulse(MSB, 32'h2);
    rd_en = 1'b1; addr = ra(MSB, 0); misc_evt = 32'h2;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; misc_evt = '0;
    chk("R11", "colliding read returns bit", v, 32'h2);
    rd_chk("R11", "cor collision keeps bit", ra(MSB, 0), 32'h2);
    rd_chk("R4", "next read clears", ra(MSB, 0), 32'h0);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_event_w1c();
    t_mask();
    t_swset();
    t_cor();
    t_irq();
    t_smask();
    t_map();
    t_collide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule